// File: doc/BRIEF.md
# Interleaved Multichannel Stimulation Pulse Scheduler

This block sits after an eight-channel filter bank and envelope stage. It turns the per-channel envelope words into a stream of stimulation pulses. The pulses visit the channels strictly one after another in a fixed rotating order. Each channel gets its pulse in its own time slot, so two channels are never driven at the same moment. Every pulse amplitude is the channel's envelope passed through a compressive piecewise-linear curve. Because the amplitude is taken afresh at every slot, fast changes in the envelope show up as fast changes in pulse amplitude.

The slots come from an internal clock divider. With the default of 30012 clocks per slot at a 200 MHz clock, there are about 6664 slots per second, or 833 pulses per second on each of the eight channels. A parameter can instead take the slot starts from an external rate tick.

Within a slot, the active flag stays high for the number of clocks requested on `pulse_len_i`. That length is clamped so that at least a minimum gap remains before the next channel's slot. The envelope, the compressed amplitude and the pulse length are all captured when the slot starts. Later input changes therefore do not disturb the pulse in progress.

Top module: `stim_interleaver`

## Requirements
- R1: While `rst_ni` is low, `chan_o` is 0, `amp_o` is 0 and `pulse_active_o` is 0, and all stored envelope words are cleared to 0.
- R2: With the internal divider (`EXT_TICK`=0), a slot starts on the first rising clock edge after reset is released and then every `SLOT_CLKS` clocks, and `rate_tick_i` has no effect.
- R3: The first slot after reset serves channel 0, and each later slot serves the next channel, wrapping from `N_CH`-1 back to 0.
- R4: `chan_o` and `amp_o` change only at a slot start and hold for the whole slot; an envelope update after the slot start does not change the amplitude of that slot.
- R5: When `env_valid_i` is high, the block stores all channel envelopes, with channel k's 12-bit word at `env_i[12k+11:12k]`. A strobe in the same cycle as a slot start supplies the value used for that slot.
- R6: `pulse_active_o` rises at the slot start edge and stays high for exactly min(`pulse_len_i`, `SLOT_CLKS`-`MIN_GAP_CLKS`) clocks, with `pulse_len_i` sampled at the slot start. A length of 0 gives no pulse in that slot.
- R7: The amplitude is computed as follows. s = env[11:8] and f = env[7:0]. The knots K0..K16 are 0, 40, 72, 98, 120, 139, 155, 169, 182, 194, 205, 215, 224, 233, 241, 248, 255. The amplitude is K[s] + floor((K[s+1]-K[s])*f/256), which is monotonic and never exceeds 254.
- R8: `pulse_active_o` is low in the last clock of every slot, so the pulse of one channel never overlaps or touches the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| env_i | input | N_CH*12 | Envelope words, channel k at bits 12k+11..12k |
| env_valid_i | input | 1 | Strobe: store all envelope words |
| rate_tick_i | input | 1 | External slot tick, used only when EXT_TICK=1 |
| pulse_len_i | input | LEN_W | Requested pulse length in clocks |
| chan_o | output | CH_W | Channel served in the current slot |
| amp_o | output | 8 | Compressed pulse amplitude of the current slot |
| pulse_active_o | output | 1 | High while the pulse is being delivered |

## Verification
The bound checker tests several properties on every cycle. It checks the rotate-by-one step of the channel index and that channel and amplitude stay stable between slot starts. It also checks that a pulse rises only at a slot start, that no pulse run exceeds the clamped maximum, that the output is quiet in the slot's last clock, that slots are exactly `SLOT_CLKS` apart, and the 254 ceiling on the amplitude. Some behaviour only the bench scenarios can show, because it depends on input values and their timing: the exact compressed values at chosen knots, the bit position of each channel's word, the same-cycle strobe bypass, the mid-slot update being held off, and the exact pulse length after clamping or a zero request.

// File: rtl/stim_pkg.sv
package stim_pkg;

  localparam int ENV_W  = 12;
  localparam int AMP_W  = 8;
  localparam int SEG_W  = 4;
  localparam int FRAC_W = ENV_W - SEG_W;
  localparam int SLP_W  = 6;
  localparam int PROD_W = SLP_W + FRAC_W;

  // Start value of each compression segment.
  function automatic logic [AMP_W-1:0] seg_base(input logic [SEG_W-1:0] s);
    logic [AMP_W-1:0] b;
    case (s)
      4'd0:    b = 8'd0;
      4'd1:    b = 8'd40;
      4'd2:    b = 8'd72;
      4'd3:    b = 8'd98;
      4'd4:    b = 8'd120;
      4'd5:    b = 8'd139;
      4'd6:    b = 8'd155;
      4'd7:    b = 8'd169;
      4'd8:    b = 8'd182;
      4'd9:    b = 8'd194;
      4'd10:   b = 8'd205;
      4'd11:   b = 8'd215;
      4'd12:   b = 8'd224;
      4'd13:   b = 8'd233;
      4'd14:   b = 8'd241;
      default: b = 8'd248;
    endcase
    return b;
  endfunction

  // Rise of each segment; all positive, so the curve is monotonic.
  function automatic logic [SLP_W-1:0] seg_slope(input logic [SEG_W-1:0] s);
    logic [SLP_W-1:0] r;
    case (s)
      4'd0:    r = 6'd40;
      4'd1:    r = 6'd32;
      4'd2:    r = 6'd26;
      4'd3:    r = 6'd22;
      4'd4:    r = 6'd19;
      4'd5:    r = 6'd16;
      4'd6:    r = 6'd14;
      4'd7:    r = 6'd13;
      4'd8:    r = 6'd12;
      4'd9:    r = 6'd11;
      4'd10:   r = 6'd10;
      4'd11:   r = 6'd9;
      4'd12:   r = 6'd9;
      4'd13:   r = 6'd8;
      4'd14:   r = 6'd7;
      default: r = 6'd7;
    endcase
    return r;
  endfunction

  // Piecewise-linear compression of one envelope word.
  function automatic logic [AMP_W-1:0] compress_env(input logic [ENV_W-1:0] e);
    logic [SEG_W-1:0]  s;
    logic [PROD_W-1:0] p;
    s = e[ENV_W-1 -: SEG_W];
    p = PROD_W'(seg_slope(s)) * PROD_W'(e[FRAC_W-1:0]);
    return seg_base(s) + AMP_W'(p[PROD_W-1 -: SLP_W]);
  endfunction

endpackage

// File: rtl/stim_slot_timer.sv
module stim_slot_timer #(
  parameter int SLOT_CLKS = 30012,
  parameter bit EXT_TICK  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_tick_i,
  output logic slot_tick_o
);

  localparam int CNT_W = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CLKS - 1);

  if (EXT_TICK) begin : g_ext
    assign slot_tick_o = ext_tick_i;
  end else begin : g_div
    logic [CNT_W-1:0] cnt_q;
    logic             unused_ext;

    assign unused_ext = ext_tick_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    // The slot starts on the edge at which the count is zero.
    assign slot_tick_o = (cnt_q == '0);
  end

endmodule

// File: rtl/stim_env_bank.sv
module stim_env_bank #(
  parameter int N_CH  = 8,
  parameter int ENV_W = 12,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CH*ENV_W-1:0]   env_i,
  input  logic                    valid_i,
  input  logic [CH_W-1:0]         sel_i,
  output logic [ENV_W-1:0]        env_sel_o
);

  logic [N_CH-1:0][ENV_W-1:0] bank_q;
  logic [N_CH-1:0][ENV_W-1:0] env_in;

  assign env_in = env_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (valid_i) begin
      bank_q <= env_in;
    end
  end

  // A word arriving in this cycle bypasses the store.
  assign env_sel_o = valid_i ? env_in[sel_i] : bank_q[sel_i];

endmodule

// File: rtl/stim_compressor.sv
module stim_compressor
  import stim_pkg::*;
(
  input  logic [ENV_W-1:0] env_i,
  output logic [AMP_W-1:0] amp_o
);

  assign amp_o = compress_env(env_i);

endmodule

// File: rtl/stim_pulse_seq.sv
module stim_pulse_seq #(
  parameter int N_CH         = 8,
  parameter int SLOT_CLKS    = 30012,
  parameter int MIN_GAP_CLKS = 2,
  parameter int AMP_W        = 8,
  parameter int CH_W         = $clog2(N_CH),
  parameter int LEN_W        = $clog2(SLOT_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_tick_i,
  input  logic [AMP_W-1:0] amp_next_i,
  input  logic [LEN_W-1:0] pulse_len_i,
  output logic [CH_W-1:0]  ch_next_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [AMP_W-1:0] amp_o,
  output logic             active_o,
  output logic             started_o
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(SLOT_CLKS - MIN_GAP_CLKS);
  localparam logic [CH_W-1:0]  CH_LAST = CH_W'(N_CH - 1);

  logic             started_q;
  logic [CH_W-1:0]  ch_q;
  logic [AMP_W-1:0] amp_q;
  logic [LEN_W-1:0] rem_q;
  logic             active_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff   = (pulse_len_i > MAX_LEN) ? MAX_LEN : pulse_len_i;
  assign ch_next_o = (!started_q || ch_q == CH_LAST) ? '0 : ch_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      ch_q      <= '0;
      amp_q     <= '0;
      rem_q     <= '0;
      active_q  <= 1'b0;
    end else if (slot_tick_i) begin
      started_q <= 1'b1;
      ch_q      <= ch_next_o;
      amp_q     <= amp_next_i;
      rem_q     <= len_eff;
      active_q  <= (len_eff != '0);
    end else if (rem_q != '0) begin
      rem_q     <= rem_q - 1'b1;
      active_q  <= (rem_q > LEN_W'(1));
    end else begin
      active_q  <= 1'b0;
    end
  end

  assign ch_o      = ch_q;
  assign amp_o     = amp_q;
  assign active_o  = active_q;
  assign started_o = started_q;

endmodule

// File: rtl/stim_interleaver.sv
module stim_interleaver
  import stim_pkg::*;
#(
  parameter int N_CH         = 8,
  parameter int SLOT_CLKS    = 30012,
  parameter int MIN_GAP_CLKS = 2,
  parameter bit EXT_TICK     = 1'b0,
  localparam int CH_W        = $clog2(N_CH),
  localparam int LEN_W       = $clog2(SLOT_CLKS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH*ENV_W-1:0] env_i,
  input  logic                  env_valid_i,
  input  logic                  rate_tick_i,
  input  logic [LEN_W-1:0]      pulse_len_i,
  output logic [CH_W-1:0]       chan_o,
  output logic [AMP_W-1:0]      amp_o,
  output logic                  pulse_active_o
);

  // Internal events, named for the checker.
  logic             slot_tick;
  logic [CH_W-1:0]  ch_next;
  logic [ENV_W-1:0] env_next;
  logic [AMP_W-1:0] amp_next;
  logic             seq_started;

  stim_slot_timer #(
    .SLOT_CLKS (SLOT_CLKS),
    .EXT_TICK  (EXT_TICK)
  ) timer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_tick_i  (rate_tick_i),
    .slot_tick_o (slot_tick)
  );

  stim_env_bank #(
    .N_CH  (N_CH),
    .ENV_W (ENV_W),
    .CH_W  (CH_W)
  ) bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .env_i     (env_i),
    .valid_i   (env_valid_i),
    .sel_i     (ch_next),
    .env_sel_o (env_next)
  );

  stim_compressor comp_i (
    .env_i (env_next),
    .amp_o (amp_next)
  );

  stim_pulse_seq #(
    .N_CH         (N_CH),
    .SLOT_CLKS    (SLOT_CLKS),
    .MIN_GAP_CLKS (MIN_GAP_CLKS),
    .AMP_W        (AMP_W),
    .CH_W         (CH_W),
    .LEN_W        (LEN_W)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_tick_i (slot_tick),
    .amp_next_i  (amp_next),
    .pulse_len_i (pulse_len_i),
    .ch_next_o   (ch_next),
    .ch_o        (chan_o),
    .amp_o       (amp_o),
    .active_o    (pulse_active_o),
    .started_o   (seq_started)
  );

endmodule

// File: rtl/stim_interleaver_chk.sv
module stim_interleaver_chk #(
  parameter int N_CH         = 8,
  parameter int SLOT_CLKS    = 30012,
  parameter int MIN_GAP_CLKS = 2,
  parameter bit EXT_TICK     = 1'b0,
  parameter int CH_W         = 3,
  parameter int AMP_W        = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_tick,
  input logic             started,
  input logic [CH_W-1:0]  ch_o,
  input logic [AMP_W-1:0] amp_o,
  input logic             active_o
);

  localparam int unsigned MAX_LEN = SLOT_CLKS - MIN_GAP_CLKS;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(N_CH - 1);

  int unsigned run_q;
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 0;
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      run_q  <= active_o ? run_q + 1 : 0;
      gap_q  <= slot_tick ? 0 : gap_q + 1;
      seen_q <= seen_q | slot_tick;
    end
  end

  // R3: channel advances by one with wrap
  a_r3_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick && started) |=>
      (ch_o == (($past(ch_o) == CH_LAST) ? '0 : CH_W'($past(ch_o) + 1'b1))));

  // R4: outputs frozen between slot starts
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick |=> ($stable(ch_o) && $stable(amp_o)));

  // R6: a pulse begins only at a slot start
  a_r6_rise_at_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(slot_tick));

  // R6: no pulse longer than the clamp
  a_r6_max_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (run_q < MAX_LEN));

  // R8: quiet in the last clock of a slot
  a_r8_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_tick |-> !active_o);

  // R7: amplitude ceiling
  a_r7_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_o <= AMP_W'(254));

  if (!EXT_TICK) begin : g_period
    // R2: slots exactly SLOT_CLKS apart
    a_r2_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_tick && seen_q) |-> (gap_q == SLOT_CLKS - 1));
  end

endmodule

bind stim_interleaver stim_interleaver_chk #(
  .N_CH         (N_CH),
  .SLOT_CLKS    (SLOT_CLKS),
  .MIN_GAP_CLKS (MIN_GAP_CLKS),
  .EXT_TICK     (EXT_TICK),
  .CH_W         (CH_W),
  .AMP_W        (AMP_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .slot_tick (slot_tick),
  .started   (seq_started),
  .ch_o      (chan_o),
  .amp_o     (amp_o),
  .active_o  (pulse_active_o)
);

// File: tb/stim_interleaver_tb_top.sv
`timescale 1ns/1ps
module stim_interleaver_tb_top;

  localparam int NCH  = 8;
  localparam int EW   = 12;
  localparam int SLOT = 24;
  localparam int GAP  = 2;
  localparam int LW   = $clog2(SLOT + 1);
  localparam int MAXL = SLOT - GAP;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*EW-1:0] env = '0;
  logic              env_vld = 1'b0;
  logic              rtick = 1'b0;
  logic [LW-1:0]     plen = LW'(5);
  logic [2:0]        chan;
  logic [7:0]        amp;
  logic              act;

  stim_interleaver #(
    .N_CH         (NCH),
    .SLOT_CLKS    (SLOT),
    .MIN_GAP_CLKS (GAP),
    .EXT_TICK     (1'b0)
  ) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .env_i          (env),
    .env_valid_i    (env_vld),
    .rate_tick_i    (rtick),
    .pulse_len_i    (plen),
    .chan_o         (chan),
    .amp_o          (amp),
    .pulse_active_o (act)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  int knots[17] = '{0, 40, 72, 98, 120, 139, 155, 169, 182, 194, 205, 215,
                    224, 233, 241, 248, 255};

  function automatic int ref_amp(int e);
    int s;
    int f;
    s = e / 256;
    f = e % 256;
    return knots[s] + ((knots[s+1] - knots[s]) * f) / 256;
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, actual, expected, cyc);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int m_cnt, m_ch, m_amp, m_rem, m_act, m_started;
  int m_bank[NCH];
  int m_now[NCH];
  int m_starts[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ch = 0; m_amp = 0; m_rem = 0; m_act = 0; m_started = 0;
      for (int k = 0; k < NCH; k++) m_bank[k] = 0;
    end else begin
      for (int k = 0; k < NCH; k++)
        m_now[k] = env_vld ? int'(env[k*EW +: EW]) : m_bank[k];
      if (m_cnt == 0) begin
        int len;
        m_ch = m_started ? (m_ch + 1) % NCH : 0;
        m_started = 1;
        m_amp = ref_amp(m_now[m_ch]);
        len = (int'(plen) > MAXL) ? MAXL : int'(plen);
        m_rem = len;
        m_act = (len != 0);
        m_starts.push_back(cyc);
      end else if (m_rem > 0) begin
        m_rem--;
        m_act = (m_rem > 0);
      end else begin
        m_act = 0;
      end
      if (env_vld)
        for (int k = 0; k < NCH; k++) m_bank[k] = m_now[k];
      m_cnt = (m_cnt + 1) % SLOT;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 channel index", int'(chan), m_ch);
      check("R4 R7 slot amplitude", int'(amp), m_amp);
      check("R6 pulse active", int'(act), m_act);
      if (m_cnt == 0) check("R8 quiet before slot start", int'(act), 0);
    end
  end

  // rate_tick_i noise: must not matter in divider mode (R2).
  always @(negedge clk) rtick <= $urandom_range(0, 1) == 1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=200000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_all(int v);
    for (int k = 0; k < NCH; k++) env[k*EW +: EW] = EW'(v);
    env_vld = 1'b1;
    @(negedge clk);
    env_vld = 1'b0;
  endtask

  // Return at the negedge just before a slot-start edge.
  task automatic to_slot_edge();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic amp_after(int v, int expv, string tag);
    set_all(v);
    to_slot_edge();
    @(negedge clk);
    check(tag, int'(amp), expv);
  endtask

  int t0;
  int n;
  int a0;

  initial begin
    // R1: reset state, with strobed data that must not be stored
    for (int k = 0; k < NCH; k++) env[k*EW +: EW] = 12'hABC;
    env_vld = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset chan", int'(chan), 0);
    check("R1 reset amp", int'(amp), 0);
    check("R1 reset active", int'(act), 0);
    env_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 first slot channel", int'(chan), 0);
    check("R1 cleared store gives zero amplitude", int'(amp), 0);
    check("R2 first slot at first edge", m_starts.size(), 1);

    // R2: slot spacing, with rate_tick_i toggling
    to_slot_edge(); @(negedge clk); t0 = cyc;
    to_slot_edge(); @(negedge clk);
    check("R2 slot spacing", cyc - t0, SLOT);

    // R7: compression at chosen points
    amp_after(12'h000, 0, "R7 env 0x000");
    amp_after(12'h0FF, 39, "R7 env 0x0FF");
    amp_after(12'h180, 56, "R7 env 0x180");
    amp_after(12'h880, 188, "R7 env 0x880");
    amp_after(12'hFFF, 254, "R7 env 0xFFF");

    // R3: rotation order across a wrap
    for (int k = 0; k < NCH; k++) env[k*EW +: EW] = EW'(k * 512 + 100);
    env_vld = 1'b1; @(negedge clk); env_vld = 1'b0;
    to_slot_edge(); @(negedge clk);
    a0 = int'(chan);
    for (int i = 1; i <= NCH + 1; i++) begin
      to_slot_edge(); @(negedge clk);
      check("R3 rotation order", int'(chan), (a0 + i) % NCH);
    end

    // R5: field position, channel 3 only
    env = '0; env[3*EW +: EW] = 12'hFFF;
    env_vld = 1'b1; @(negedge clk); env_vld = 1'b0;
    while (!(m_cnt == 0 && m_ch == 2)) @(negedge clk);
    @(negedge clk);
    check("R5 channel 3 word", int'(amp), 254);
    to_slot_edge(); @(negedge clk);
    check("R5 channel 4 word", int'(amp), 0);

    // R5: strobe in the slot-start cycle is used
    to_slot_edge();
    set_all(12'h880);
    check("R5 same-cycle strobe", int'(amp), 188);

    // R4: mid-slot update does not change the slot's amplitude
    set_all(12'h000);
    to_slot_edge(); @(negedge clk);
    repeat (3) @(negedge clk);
    set_all(12'hFFF);
    check("R4 held through slot", int'(amp), 0);

    // R6: pulse length, clamp and zero
    plen = LW'(7);
    to_slot_edge(); n = 0;
    repeat (SLOT) begin @(negedge clk); n += int'(act); end
    check("R6 length 7", n, 7);
    plen = LW'(30);
    to_slot_edge(); n = 0;
    repeat (SLOT) begin @(negedge clk); n += int'(act); end
    check("R6 clamped length", n, MAXL);
    plen = LW'(0);
    to_slot_edge(); n = 0;
    repeat (SLOT) begin @(negedge clk); n += int'(act); end
    check("R6 zero length", n, 0);

    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      env_vld = ($urandom_range(0, 3) == 0);
      for (int k = 0; k < NCH; k++) env[k*EW +: EW] = EW'($urandom_range(0, 4095));
      if ($urandom_range(0, 15) == 0) plen = LW'($urandom_range(0, 31));
    end
    env_vld = 1'b0;
    repeat (2 * SLOT) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule